// File: doc/BRIEF.md
# Register-Driven Serial EEPROM Responder

This block stands in for a small serial EEPROM that host software reaches through one 32-bit control register. Software toggles a clock bit, a chip-select bit and a data-in bit by writing the register. The responder looks for writes that move the stored clock bit from 0 to 1, and treats each one as one serial clock edge. Across those edges it takes in an 8-bit command and, for a read, an 8-bit word address. It then returns the addressed 16-bit word one bit at a time on a data-out bit of the same register, lowest bit first. A status command returns eight zero bits. Any other command, or an address beyond the storage, raises an error output that stays set until reset.

The sequencer has five named states. OPCODE takes in the command. ADDRESS takes in the word address. READ_DATA returns the word. STATUS returns the status bits. FAULT holds the block after an error. The transitions are:
- opc_read (OPCODE→ADDRESS) after the 8th command bit when the command is 0x03.
- opc_status (OPCODE→STATUS) after the 8th command bit when the command is 0x05.
- opc_bad (OPCODE→FAULT) after the 8th command bit for any other command.
- addr_ok (ADDRESS→READ_DATA) after the 8th address bit when the address is below the depth.
- addr_bad (ADDRESS→FAULT) after the 8th address bit when the address is at or beyond the depth.
- data_done (READ_DATA→OPCODE) after the 16th data bit.
- status_done (STATUS→OPCODE) after the 8th status bit.
- fault_hold (FAULT→FAULT) on every clock edge.

The access grant bit copies the request bit on every accepted write.

Top module: `sreep_top`

## Requirements
- R1: After reset, `rd_data` reads 0x00002010: the write-enable field (bits 5:4) is 1, the type bit (bit 13) is 1 and every other bit is 0. After reset `err` is 0 and the sequencer is in OPCODE.
- R2: A write is accepted only when `wr_be` is 4'hF. A write with any other byte-enable value changes nothing: not `rd_data`, not `err`, and not the sequencer.
- R3: An accepted write stores the written value in every bit except two. Bit 3 (data-out) is owned by the responder and ignores the written value. Bit 7 (grant) takes the value of bit 6 (request) of the same write.
- R4: A serial step happens only on an accepted write whose bit 0 is 1 while the stored bit 0 is 0. Any other write leaves data-out and the sequencer unchanged.
- R5: In OPCODE, the first 8 steps shift bit 2 (data-in) into the command, most significant bit first.
- R6: For command 0x03, the next 8 steps shift data-in into the word address, most significant bit first. The following 16 steps each set data-out to one bit of the addressed word, from bit 0 up to bit 15.
- R7: For command 0x05, the next 8 steps each set data-out to 0.
- R8: After the 16th data step or the 8th status step, the command, the address and the counters clear. The next step starts a new command in OPCODE.
- R9: A command other than 0x03 or 0x05 sets `err` after its 8th bit, and the sequencer enters FAULT.
- R10: A read address of 64 or more sets `err` and returns no data: data-out keeps its value. `err` stays set until reset, whatever the later steps are.
- R11: Storage holds 64 words of 16 bits. Word 0 holds 0xBABA and every other word holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Byte enables of the write; only 4'hF is accepted |
| wr_data | input | 32 | Value written to the control register |
| rd_data | output | 32 | Current control register contents, including data-out and grant |
| err | output | 1 | Sticky protocol error |

## Verification
The hardest cases to reach are the sticky FAULT state and the check that a write without a rising clock bit does nothing. Both can only be reached by building whole serial transactions from pairs of register writes.

The bench drives every bit as a write with the clock bit low followed by a write with the clock bit high. It can repeat the high write, and the word it reads back must still match, which shows that the repeated write caused no step. The error cases are reached by sending a complete bad command, and a complete read whose address is 64. For the bad address, a read of word 0 runs first, so data-out is left at 1 and can be seen to hold.

// File: rtl/sreep_pkg.sv
package sreep_pkg;
    localparam int CTL_W  = 32;
    localparam int B_CLK  = 0;
    localparam int B_CS   = 1;
    localparam int B_DIN  = 2;
    localparam int B_DOUT = 3;
    localparam int B_REQ  = 6;
    localparam int B_GNT  = 7;
    localparam logic [CTL_W-1:0] CTL_RESET = 32'h0000_2010;
    localparam logic [7:0] OPC_READ = 8'h03;
    localparam logic [7:0] OPC_STAT = 8'h05;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_ADDR,
        ST_RDATA,
        ST_STATUS,
        ST_FAULT
    } sr_state_t;
endpackage

// File: rtl/sreep_store.sv
module sreep_store #(
    parameter int DEPTH  = 64,
    parameter int WORD_W = 16,
    parameter logic [WORD_W-1:0] INIT0 = 16'hBABA,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic [AW-1:0]     rd_idx,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] words [DEPTH];

    // Read-only contents: word 0 carries the checksum pattern, the rest are blank.
    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        if (i == 0) begin : g_first
            assign words[i] = INIT0;
        end else begin : g_rest
            assign words[i] = '0;
        end
    end

    assign rd_word = words[rd_idx];
endmodule

// File: rtl/sreep_ctlreg.sv
module sreep_ctlreg
    import sreep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [3:0]       wr_be,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             dout,
    output logic             step,
    output logic             din,
    output logic [CTL_W-1:0] view
);
    logic [CTL_W-1:0] ctl_q;
    logic             wr_full;

    assign wr_full = wr_en && (wr_be == 4'hF);
    // A step is a full write that raises the stored clock bit.
    assign step    = wr_full && !ctl_q[B_CLK] && wr_data[B_CLK];
    assign din     = wr_data[B_DIN];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
        end else if (wr_full) begin
            ctl_q         <= wr_data;
            ctl_q[B_DOUT] <= 1'b0;
            ctl_q[B_GNT]  <= wr_data[B_REQ];
        end
    end

    always_comb begin
        view         = ctl_q;
        view[B_DOUT] = dout;
    end
endmodule

// File: rtl/sreep_seq.sv
module sreep_seq
    import sreep_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int WORD_W = 16,
    parameter int OP_W   = 8,
    parameter int ADDR_W = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int BW    = $clog2(WORD_W),
    localparam int CW    = BW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              din,
    input  logic [WORD_W-1:0] word,
    output logic [AW-1:0]     rd_idx,
    output logic              dout,
    output logic              err,
    output sr_state_t         state
);
    sr_state_t         st_q, st_n;
    logic [OP_W-1:0]   op_q, op_n, op_sh;
    logic [ADDR_W-1:0] addr_q, addr_n, addr_sh;
    logic [CW-1:0]     cnt_q, cnt_n;
    logic              dout_q, dout_n;
    logic              err_q, err_n;

    assign op_sh   = {op_q[OP_W-2:0], din};
    assign addr_sh = {addr_q[ADDR_W-2:0], din};

    // State and datapath register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_OPCODE;
            op_q   <= '0;
            addr_q <= '0;
            cnt_q  <= '0;
            dout_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            st_q   <= st_n;
            op_q   <= op_n;
            addr_q <= addr_n;
            cnt_q  <= cnt_n;
            dout_q <= dout_n;
            err_q  <= err_n;
        end
    end

    // Next state and datapath on each serial step.
    always_comb begin
        st_n   = st_q;
        op_n   = op_q;
        addr_n = addr_q;
        cnt_n  = cnt_q;
        dout_n = dout_q;
        err_n  = err_q;
        if (step) begin
            unique case (st_q)
                ST_OPCODE: begin
                    op_n  = op_sh;
                    cnt_n = cnt_q + 1'b1;
                    if (cnt_q == CW'(OP_W - 1)) begin
                        cnt_n = '0;
                        if (op_sh == OPC_READ) begin
                            st_n = ST_ADDR;
                        end else if (op_sh == OPC_STAT) begin
                            st_n = ST_STATUS;
                        end else begin
                            st_n  = ST_FAULT;
                            err_n = 1'b1;
                        end
                    end
                end
                ST_ADDR: begin
                    addr_n = addr_sh;
                    cnt_n  = cnt_q + 1'b1;
                    if (cnt_q == CW'(ADDR_W - 1)) begin
                        cnt_n = '0;
                        if ({1'b0, addr_sh} >= (ADDR_W+1)'(DEPTH)) begin
                            st_n  = ST_FAULT;
                            err_n = 1'b1;
                        end else begin
                            st_n = ST_RDATA;
                        end
                    end
                end
                ST_RDATA: begin
                    dout_n = word[cnt_q[BW-1:0]];
                    cnt_n  = cnt_q + 1'b1;
                    if (cnt_q == CW'(WORD_W - 1)) begin
                        st_n   = ST_OPCODE;
                        cnt_n  = '0;
                        op_n   = '0;
                        addr_n = '0;
                    end
                end
                ST_STATUS: begin
                    dout_n = 1'b0;
                    cnt_n  = cnt_q + 1'b1;
                    if (cnt_q == CW'(OP_W - 1)) begin
                        st_n   = ST_OPCODE;
                        cnt_n  = '0;
                        op_n   = '0;
                        addr_n = '0;
                    end
                end
                ST_FAULT: begin
                    st_n  = ST_FAULT;
                    err_n = 1'b1;
                end
                default: begin
                    st_n  = ST_FAULT;
                    err_n = 1'b1;
                end
            endcase
        end
    end

    // Outputs.
    always_comb begin
        rd_idx = addr_q[AW-1:0];
        dout   = dout_q;
        err    = err_q;
        state  = st_q;
    end
endmodule

// File: rtl/sreep_top.sv
module sreep_top
    import sreep_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int WORD_W = 16,
    parameter logic [WORD_W-1:0] INIT0 = 16'hBABA,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  wr_be,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        err
);
    logic              step;
    logic              din;
    logic              dout;
    logic [AW-1:0]     rd_idx;
    logic [WORD_W-1:0] word;
    sr_state_t         seq_state;

    sreep_ctlreg u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .dout    (dout),
        .step    (step),
        .din     (din),
        .view    (rd_data)
    );

    sreep_seq #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .din    (din),
        .word   (word),
        .rd_idx (rd_idx),
        .dout   (dout),
        .err    (err),
        .state  (seq_state)
    );

    sreep_store #(.DEPTH(DEPTH), .WORD_W(WORD_W), .INIT0(INIT0)) u_store (
        .rd_idx  (rd_idx),
        .rd_word (word)
    );
endmodule

// File: rtl/sreep_chk.sv
module sreep_chk
    import sreep_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [3:0]  wr_be,
    input logic        wr_clk,
    input logic        wr_req,
    input logic [31:0] rd_data,
    input logic        err,
    input sr_state_t   seq_state
);
    logic wr_full, edge_w;
    assign wr_full = wr_en && (wr_be == 4'hF);
    assign edge_w  = wr_full && !rd_data[B_CLK] && wr_clk;

    // R3: grant follows the request bit of the same write
    p_grant_mirror_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_full |=> rd_data[B_GNT] == $past(wr_req));

    // R2: partial writes leave everything unchanged
    p_partial_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be != 4'hF) |=> $stable(rd_data) && $stable(err) && $stable(seq_state));

    // R4: no step, no change of data-out or sequencer
    p_no_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_w |=> $stable(rd_data[B_DOUT]) && $stable(seq_state));

    // R10: error is sticky
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R7: status bits are zero
    p_status_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_w && seq_state == ST_STATUS) |=> !rd_data[B_DOUT]);

    // R9: the fault state always shows the error
    p_fault_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_FAULT) |-> err);
endmodule

bind sreep_top sreep_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_be     (wr_be),
    .wr_clk    (wr_data[0]),
    .wr_req    (wr_data[6]),
    .rd_data   (rd_data),
    .err       (err),
    .seq_state (seq_state)
);

// File: tb/test_sreep_top.sv
`timescale 1ns/1ps
module test_sreep_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_be = 4'h0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    localparam logic [31:0] BASE = 32'h0000_2012;

    // {opcode, address, repeat-high flag, expected 16-bit result}
    localparam logic [32:0] VEC [6] = '{
        {8'h03, 8'h00, 1'b0, 16'hBABA},
        {8'h05, 8'h00, 1'b0, 16'h0000},
        {8'h03, 8'h01, 1'b0, 16'h0000},
        {8'h03, 8'h00, 1'b1, 16'hBABA},
        {8'h03, 8'h3F, 1'b1, 16'h0000},
        {8'h03, 8'h00, 1'b0, 16'hBABA}
    };

    always #2 clk = ~clk;

    sreep_top i_sreep_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .err     (err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_be   = be;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_bit(input logic b, input logic dup);
        wr(BASE | (32'(b) << 2), 4'hF);
        wr(BASE | (32'(b) << 2) | 32'h1, 4'hF);
        if (dup) wr(BASE | (32'(b) << 2) | 32'h1, 4'hF);
    endtask

    task automatic do_cmd(input logic [7:0] op, input logic [7:0] addr, input logic dup,
                          output logic [15:0] got);
        int nout;
        got = '0;
        for (int i = 7; i >= 0; i--) send_bit(op[i], 1'b0);
        if (op == 8'h03) begin
            for (int i = 7; i >= 0; i--) send_bit(addr[i], 1'b0);
            nout = 16;
        end else begin
            nout = 8;
        end
        for (int i = 0; i < nout; i++) begin
            send_bit(1'b0, dup);
            got[i] = rd_data[3];
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] got;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        check("R1 reset rd_data", rd_data, 32'h0000_2010);
        check("R1 reset err", 32'(err), 32'h0);

        // R2: partial write ignored
        wr(32'hFFFF_FFFF, 4'h7);
        check("R2 partial write", rd_data, 32'h0000_2010);
        check("R2 partial write err", 32'(err), 32'h0);

        // R3: request mirrored to grant, data-out not writable
        wr(32'h0000_0040, 4'hF);
        check("R3 grant mirror", rd_data, 32'h0000_00C0);
        wr(32'h0000_0088, 4'hF);
        check("R3 dout and grant not writable", rd_data, 32'h0000_0000);

        // R5 R6 R7 R8 R11 (and R4 for entries with repeated high writes)
        foreach (VEC[k]) begin
            do_cmd(VEC[k][32:25], VEC[k][24:17], VEC[k][16], got);
            check($sformatf("R6 R7 R8 R11 R4 vector %0d", k), 32'(got), 32'(VEC[k][15:0]));
            check($sformatf("R8 no error vector %0d", k), 32'(err), 32'h0);
        end

        // R9: unknown opcode
        for (int i = 7; i >= 0; i--) send_bit(logic'((8'h07 >> i) & 8'h1), 1'b0);
        check("R9 bad opcode err", 32'(err), 32'h1);

        // R10: out-of-range address after data-out is left at 1
        do_reset();
        check("R1 err clears on reset", 32'(err), 32'h0);
        do_cmd(8'h03, 8'h00, 1'b0, got);
        check("R11 word 0", 32'(got), 32'h0000_BABA);
        for (int i = 7; i >= 0; i--) send_bit(logic'((8'h03 >> i) & 8'h1), 1'b0);
        for (int i = 7; i >= 0; i--) send_bit(logic'((8'h40 >> i) & 8'h1), 1'b0);
        check("R10 address 64 err", 32'(err), 32'h1);
        check("R10 no data returned", 32'(rd_data[3]), 32'h1);
        for (int i = 0; i < 10; i++) send_bit(1'b1, 1'b0);
        check("R10 err sticky", 32'(err), 32'h1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule